// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block takes a DDR SDRAM device from reset to its first usable state. After a synchronous reset it holds the clock enable low for a power-up hold of many cycles. It then raises the clock enable, sends a single NOP and issues a fixed series of commands with counted idle gaps between them. The series is: a precharge of all banks, the extended mode load, a mode load that resets the DLL, a second precharge of all banks, and two auto-refresh commands. A final mode load that clears the DLL reset bit may follow. It is fitted by a parameter.

The memory controller places this sequencer in front of its command bus. It keeps normal traffic off that bus until the ready flag rises. A second flag, read-allowed, holds reads back until the DLL has had a fixed cycle budget to lock after its reset. The controller supplies the drive-strength choice and the operating word for the mode register. All timing intervals are cycle-count parameters.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is high, and for exactly PWRUP_CYC cycles after its release, `cke` is 0. During that time the command bus shows NOP (`{cs_n,ras_n,cas_n,we_n}` = 4'b0111) with `ba` = 0 and `addr` = 0, and `init_done` and `read_ok` are 0.
- R2: After the power-up hold, `cke` goes to 1 with exactly one NOP cycle before the first real command. `cke` then stays 1 until the next reset.
- R3: Each command lasts exactly one cycle. The commands appear in this order: precharge-all, extended load, DLL-reset load, precharge-all, refresh, refresh, and then the optional final load. After each precharge come exactly T_RP NOP cycles. After each load come exactly T_MRD NOP cycles. After each refresh come exactly T_RFC NOP cycles.
- R4: The command codes on `{cs_n,ras_n,cas_n,we_n}` are: NOP 4'b0111, PRECHARGE 4'b0010, LOAD MODE 4'b0000 and AUTO REFRESH 4'b0001. On NOP and refresh cycles, `ba` and `addr` are 0.
- R5: A precharge drives `addr` = only bit 10 set (all banks) and `ba` = 2'b00.
- R6: The extended load drives `ba` = 2'b01. On `addr`, bit 0 is 0 (DLL enabled), bit 1 equals `drive_reduced` (1 = reduced drive) and all higher bits are 0.
- R7: The DLL-reset load drives `ba` = 2'b00 and `addr` = `mode_word` with bit 8 forced to 1.
- R8: With FINAL_LMR = 1, the final load drives `ba` = 2'b00 and `addr` = `mode_word` with bit 8 forced to 0, followed by T_MRD NOP cycles. With FINAL_LMR = 0 this step and its wait are skipped.
- R9: `init_done` rises in the first cycle after the last wait and stays 1 until reset. While it is 1 the bus holds NOP with `cke` = 1.
- R10: `read_ok` is 1 exactly when `init_done` is 1 and at least DLL_CYC cycles have passed since the DLL-reset load cycle. Once high it stays high until reset.
- R11: A reset at any point of the sequence, or after it, returns the block to the R1 state and clears `init_done` and `read_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| drive_reduced | input | 1 | Drive-strength select for the extended load (1 = reduced) |
| mode_word | input | ADDR_W | Operating parameters for the mode register loads |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address / register select |
| addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Sequence complete, normal commands allowed |
| read_ok | output | 1 | Reads allowed (DLL lock budget met) |

## Verification
A state register that skips or repeats a step shows up on the command bus. The cycle it enters the wrong step, a command code or address appears out of place, or a NOP gap comes out one cycle long or short. A wrong wait counter moves every later command by the error, so the cycle-by-cycle trace comparison catches it at the first affected command. A fault in the DLL budget counter shows only at `read_ok`. Its rising edge is checked to the exact cycle, both when the budget outlasts the sequence and when the sequence outlasts the budget.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

   localparam int BA_W    = 2;
   localparam int DLL_BIT = 8;
   localparam int AP_BIT  = 10;

   typedef enum logic [4:0] {
      S_PWR, S_CKEN, S_PRE1, S_WRP1, S_EMR, S_WMRD1, S_MRSD, S_WMRD2,
      S_PRE2, S_WRP2, S_REF1, S_WRFC1, S_REF2, S_WRFC2, S_MRSC, S_WMRD3,
      S_DONE
   } init_st_t;

   // {cs_n, ras_n, cas_n, we_n}
   typedef logic [3:0] cmd_t;
   localparam cmd_t CMD_NOP = 4'b0111;
   localparam cmd_t CMD_PRE = 4'b0010;
   localparam cmd_t CMD_LMR = 4'b0000;
   localparam cmd_t CMD_REF = 4'b0001;

   function automatic logic is_wait(init_st_t s);
      return s inside {S_WRP1, S_WMRD1, S_WMRD2, S_WRP2, S_WRFC1,
                       S_WRFC2, S_WMRD3};
   endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
   parameter int CNT_W   = 8,
   parameter int RST_VAL = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= CNT_W'(RST_VAL);
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/ddr_init_fsm.sv
module ddr_init_fsm
   import ddr_init_pkg::*;
#(
   parameter int T_RP      = 3,
   parameter int T_MRD     = 2,
   parameter int T_RFC     = 15,
   parameter bit FINAL_LMR = 1'b1,
   parameter int CNT_W     = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             expired,
   output init_st_t         state,
   output logic             load,
   output logic [CNT_W-1:0] load_val
);

   init_st_t nxt;
   init_st_t after_rfc;

   generate
      if (FINAL_LMR) begin : g_tail_lmr
         assign after_rfc = S_MRSC;
      end else begin : g_tail_skip
         assign after_rfc = S_DONE;
      end
   endgenerate

   always_comb begin
      nxt = state;
      unique case (state)
         S_PWR:   if (expired) nxt = S_CKEN;
         S_CKEN:  nxt = S_PRE1;
         S_PRE1:  nxt = S_WRP1;
         S_WRP1:  if (expired) nxt = S_EMR;
         S_EMR:   nxt = S_WMRD1;
         S_WMRD1: if (expired) nxt = S_MRSD;
         S_MRSD:  nxt = S_WMRD2;
         S_WMRD2: if (expired) nxt = S_PRE2;
         S_PRE2:  nxt = S_WRP2;
         S_WRP2:  if (expired) nxt = S_REF1;
         S_REF1:  nxt = S_WRFC1;
         S_WRFC1: if (expired) nxt = S_REF2;
         S_REF2:  nxt = S_WRFC2;
         S_WRFC2: if (expired) nxt = after_rfc;
         S_MRSC:  nxt = S_WMRD3;
         S_WMRD3: if (expired) nxt = S_DONE;
         default: nxt = S_DONE;
      endcase
   end

   always_comb begin
      load     = (nxt != state) && is_wait(nxt);
      load_val = '0;
      unique case (nxt)
         S_WRP1, S_WRP2:             load_val = CNT_W'(T_RP - 1);
         S_WMRD1, S_WMRD2, S_WMRD3:  load_val = CNT_W'(T_MRD - 1);
         S_WRFC1, S_WRFC2:           load_val = CNT_W'(T_RFC - 1);
         default:                    load_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)
         state <= S_PWR;
      else
         state <= nxt;
   end

endmodule

// File: rtl/ddr_init_cmd.sv
module ddr_init_cmd
   import ddr_init_pkg::*;
#(
   parameter int ADDR_W = 13
) (
   input  init_st_t          state,
   input  logic              drive_reduced,
   input  logic [ADDR_W-1:0] mode_word,
   output logic              cke,
   output cmd_t              cmd,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr,
   output logic              done
);

   localparam logic [ADDR_W-1:0] DLL_MASK = ADDR_W'(1) << DLL_BIT;
   localparam logic [ADDR_W-1:0] AP_MASK  = ADDR_W'(1) << AP_BIT;

   always_comb begin
      cke  = (state != S_PWR);
      done = (state == S_DONE);
      cmd  = CMD_NOP;
      ba   = '0;
      addr = '0;
      unique case (state)
         S_PRE1, S_PRE2: begin
            cmd  = CMD_PRE;
            addr = AP_MASK;
         end
         S_EMR: begin
            cmd  = CMD_LMR;
            ba   = BA_W'(1);
            addr = {{(ADDR_W-2){1'b0}}, drive_reduced, 1'b0};
         end
         S_MRSD: begin
            cmd  = CMD_LMR;
            addr = mode_word | DLL_MASK;
         end
         S_MRSC: begin
            cmd  = CMD_LMR;
            addr = mode_word & ~DLL_MASK;
         end
         S_REF1, S_REF2: cmd = CMD_REF;
         default: cmd = CMD_NOP;
      endcase
   end

endmodule

// File: rtl/ddr_init_dll.sv
module ddr_init_dll #(
   parameter int DLL_CYC = 200
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic expired
);

   localparam int DW = $clog2(DLL_CYC + 1);

   logic          run;
   logic [DW-1:0] left;

   always_ff @(posedge clk) begin
      if (rst) begin
         run  <= 1'b0;
         left <= '0;
      end else if (start) begin
         run  <= 1'b1;
         left <= DW'(DLL_CYC - 1);
      end else if (run && left != '0) begin
         left <= left - 1'b1;
      end
   end

   assign expired = run && (left == '0);

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
   import ddr_init_pkg::*;
#(
   parameter int PWRUP_CYC = 50000,
   parameter int T_RP      = 3,
   parameter int T_MRD     = 2,
   parameter int T_RFC     = 15,
   parameter int DLL_CYC   = 200,
   parameter bit FINAL_LMR = 1'b1,
   parameter int ADDR_W    = 13
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              drive_reduced,
   input  logic [ADDR_W-1:0] mode_word,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [1:0]        ba,
   output logic [ADDR_W-1:0] addr,
   output logic              init_done,
   output logic              read_ok
);

   localparam int MAX_A = (T_RP > T_MRD) ? T_RP : T_MRD;
   localparam int MAX_B = (T_RFC > MAX_A) ? T_RFC : MAX_A;
   localparam int MAXV  = (PWRUP_CYC > MAX_B) ? PWRUP_CYC : MAX_B;
   localparam int CNT_W = $clog2(MAXV + 1);

   generate
      if (ADDR_W < AP_BIT + 1) begin : g_bad_aw
         $error("ADDR_W must reach the all-banks bit");
      end
      if (PWRUP_CYC < 1 || T_RP < 1 || T_MRD < 1 || T_RFC < 1) begin : g_bad_t
         $error("every wait count must be at least 1");
      end
      if (DLL_CYC < 200) begin : g_bad_dll
         $error("DLL_CYC must be at least 200");
      end
   endgenerate

   init_st_t         state;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_zero;
   logic             dll_ok;
   cmd_t             cmd;

   ddr_init_timer #(.CNT_W(CNT_W), .RST_VAL(PWRUP_CYC - 1)) u_tmr (
      .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
      .expired(tmr_zero)
   );

   ddr_init_fsm #(
      .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC),
      .FINAL_LMR(FINAL_LMR), .CNT_W(CNT_W)
   ) u_fsm (
      .clk(clk), .rst(rst), .expired(tmr_zero), .state(state),
      .load(tmr_load), .load_val(tmr_val)
   );

   ddr_init_cmd #(.ADDR_W(ADDR_W)) u_cmd (
      .state(state), .drive_reduced(drive_reduced), .mode_word(mode_word),
      .cke(cke), .cmd(cmd), .ba(ba), .addr(addr), .done(init_done)
   );

   ddr_init_dll #(.DLL_CYC(DLL_CYC)) u_dll (
      .clk(clk), .rst(rst), .start(state == S_MRSD), .expired(dll_ok)
   );

   assign {cs_n, ras_n, cas_n, we_n} = cmd;
   assign read_ok = init_done && dll_ok;

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
   parameter int DLL_CYC = 200,
   parameter int ADDR_W  = 13
) (
   input logic              clk,
   input logic              rst,
   input logic              drive_reduced,
   input logic [ADDR_W-1:0] mode_word,
   input logic              cke,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [1:0]        ba,
   input logic [ADDR_W-1:0] addr,
   input logic              init_done,
   input logic              read_ok
);

   logic [3:0] c;
   logic       is_nop, is_pre, is_lmr;
   logic       seen;
   int         since;

   assign c      = {cs_n, ras_n, cas_n, we_n};
   assign is_nop = (c == 4'b0111);
   assign is_pre = (c == 4'b0010);
   assign is_lmr = (c == 4'b0000);

   // cycles since the DLL-reset load, saturating
   always_ff @(posedge clk) begin
      if (rst) begin
         seen  <= 1'b0;
         since <= 0;
      end else if (is_lmr && ba == 2'b00 && addr[8]) begin
         seen  <= 1'b1;
         since <= 1;
      end else if (seen && since < DLL_CYC) begin
         since <= since + 1;
      end
   end

   a_r1_hold_quiet: assert property (@(posedge clk) disable iff (rst)
      !cke |-> (is_nop && !init_done && !read_ok));

   a_r2_cke_stays: assert property (@(posedge clk) disable iff (rst)
      cke |=> cke);

   a_r3_gap_after_cmd: assert property (@(posedge clk) disable iff (rst)
      !is_nop |=> is_nop);

   a_r5_pre_all: assert property (@(posedge clk) disable iff (rst)
      is_pre |-> (addr[10] && ba == 2'b00));

   a_r6_ext_load: assert property (@(posedge clk) disable iff (rst)
      (is_lmr && ba == 2'b01) |->
         (addr == {{(ADDR_W-2){1'b0}}, drive_reduced, 1'b0}));

   a_r7_dll_reset_word: assert property (@(posedge clk) disable iff (rst)
      (is_lmr && ba == 2'b00 && addr[8]) |->
         (addr == (mode_word | (ADDR_W'(1) << 8))));

   a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
      init_done |=> init_done);

   a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
      init_done |-> (is_nop && cke));

   a_r10_read_budget: assert property (@(posedge clk) disable iff (rst)
      read_ok |-> (init_done && seen && since >= DLL_CYC));

   a_r10_read_sticky: assert property (@(posedge clk) disable iff (rst)
      read_ok |=> read_ok);

endmodule

bind ddr_init_seq ddr_init_seq_chk #(.DLL_CYC(DLL_CYC), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_ddr_init_seq.sv
`timescale 1ns/1ps
module sim_ddr_init_seq;

   localparam int AW = 13;
   localparam int DLL = 200;

   // per-instance configuration: index 0 = u0, index 1 = u1
   localparam int P_PWR[2] = '{20, 10};
   localparam int P_RP [2] = '{3, 2};
   localparam int P_MRD[2] = '{2, 3};
   localparam int P_RFC[2] = '{8, 120};
   localparam bit P_FIN[2] = '{1'b1, 1'b0};

   localparam int K_LOW = 0, K_NOP = 1, K_PRE = 2, K_EMR = 3,
                  K_MRD = 4, K_REF = 5, K_MRC = 6;
   localparam int L_ONE = 0, L_PWR = 1, L_RP = 2, L_MRD = 3, L_RFC = 4;

   // expected step table: kind and length selector per step
   localparam int TBL_K[16] = '{K_LOW, K_NOP, K_PRE, K_NOP, K_EMR, K_NOP,
                                K_MRD, K_NOP, K_PRE, K_NOP, K_REF, K_NOP,
                                K_REF, K_NOP, K_MRC, K_NOP};
   localparam int TBL_L[16] = '{L_PWR, L_ONE, L_ONE, L_RP, L_ONE, L_MRD,
                                L_ONE, L_MRD, L_ONE, L_RP, L_ONE, L_RFC,
                                L_ONE, L_RFC, L_ONE, L_MRD};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic drv = 1'b0;
   logic [AW-1:0] mw = '0;
   always #2 clk = ~clk;

   logic cke0, cs0, ras0, cas0, we0, done0, rok0;
   logic cke1, cs1, ras1, cas1, we1, done1, rok1;
   logic [1:0] ba0, ba1;
   logic [AW-1:0] ad0, ad1;
   logic [21:0] obs0, obs1;

   assign obs0 = {cke0, cs0, ras0, cas0, we0, ba0, ad0, done0, rok0};
   assign obs1 = {cke1, cs1, ras1, cas1, we1, ba1, ad1, done1, rok1};

   ddr_init_seq #(.PWRUP_CYC(20), .T_RP(3), .T_MRD(2), .T_RFC(8),
                  .DLL_CYC(DLL), .FINAL_LMR(1'b1), .ADDR_W(AW)) u0 (
      .clk(clk), .rst(rst), .drive_reduced(drv), .mode_word(mw),
      .cke(cke0), .cs_n(cs0), .ras_n(ras0), .cas_n(cas0), .we_n(we0),
      .ba(ba0), .addr(ad0), .init_done(done0), .read_ok(rok0));

   ddr_init_seq #(.PWRUP_CYC(10), .T_RP(2), .T_MRD(3), .T_RFC(120),
                  .DLL_CYC(DLL), .FINAL_LMR(1'b0), .ADDR_W(AW)) u1 (
      .clk(clk), .rst(rst), .drive_reduced(drv), .mode_word(mw),
      .cke(cke1), .cs_n(cs1), .ras_n(ras1), .cas_n(cas1), .we_n(we1),
      .ba(ba1), .addr(ad1), .init_done(done1), .read_ok(rok1));

   int n_chk = 0;
   int n_bad = 0;

   function automatic logic [19:0] exp_cmd(int k, logic d, logic [AW-1:0] m);
      case (k)
         K_LOW:   return {1'b0, 4'b0111, 2'b00, 13'd0};
         K_PRE:   return {1'b1, 4'b0010, 2'b00, 13'h400};
         K_EMR:   return {1'b1, 4'b0000, 2'b01, 11'd0, d, 1'b0};
         K_MRD:   return {1'b1, 4'b0000, 2'b00, m | 13'h100};
         K_REF:   return {1'b1, 4'b0001, 2'b00, 13'd0};
         K_MRC:   return {1'b1, 4'b0000, 2'b00, m & ~13'h100};
         default: return {1'b1, 4'b0111, 2'b00, 13'd0};
      endcase
   endfunction

   function automatic string tag_of(int k, int l);
      case (k)
         K_LOW:   return "R1 power-up hold";
         K_PRE:   return "R5 precharge-all R4";
         K_EMR:   return "R6 extended load";
         K_MRD:   return "R7 DLL-reset load";
         K_REF:   return "R4 auto refresh R3";
         K_MRC:   return "R8 DLL-clear load";
         default: return (l == L_ONE) ? "R2 cke-raise NOP" : "R3 wait NOP";
      endcase
   endfunction

   function automatic int len_of(int u, int l);
      case (l)
         L_PWR:   return P_PWR[u];
         L_RP:    return P_RP[u];
         L_MRD:   return P_MRD[u];
         L_RFC:   return P_RFC[u];
         default: return 1;
      endcase
   endfunction

   function automatic logic [21:0] obs_of(int u);
      return (u == 0) ? obs0 : obs1;
   endfunction

   task automatic chk(string tag, int u, int cyc, logic [31:0] got,
                      logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s u%0d cycle %0d: actual %h expected %h",
                  tag, u, cyc, got, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // synchronous reset; checks both instances while it is held
   task automatic do_reset(string tag, int cycles);
      @(negedge clk);
      rst = 1'b1;
      repeat (cycles) @(negedge clk);
      for (int u = 0; u < 2; u++) begin
         chk({tag, " cmd bus"}, u, -1, 32'(obs_of(u) >> 2),
             32'(exp_cmd(K_LOW, drv, mw)));
         chk({tag, " init_done"}, u, -1, 32'(obs_of(u)[1]), 0);
         chk({tag, " read_ok"}, u, -1, 32'(obs_of(u)[0]), 0);
      end
      rst = 1'b0;
   endtask

   // walk the step table cycle by cycle, then a post-sequence window
   task automatic walk(int u);
      int k = 0;
      int c_dll = 0;
      int n = 0;
      for (int i = 0; i < 16; i++) begin
         if (!P_FIN[u] && i >= 14) continue;
         for (int j = 0; j < len_of(u, TBL_L[i]); j++) begin
            chk(tag_of(TBL_K[i], TBL_L[i]), u, k, 32'(obs_of(u) >> 2),
                32'(exp_cmd(TBL_K[i], drv, mw)));
            chk("R9 init_done low in sequence", u, k, 32'(obs_of(u)[1]), 0);
            chk("R10 read_ok low in sequence", u, k, 32'(obs_of(u)[0]), 0);
            if (TBL_K[i] == K_MRD) c_dll = k;
            @(negedge clk);
            k++;
         end
      end
      while (n < 20 || k < c_dll + DLL + 10) begin
         chk("R9 R8 idle NOP after sequence", u, k, 32'(obs_of(u) >> 2),
             32'(exp_cmd(K_NOP, drv, mw)));
         chk("R9 init_done high", u, k, 32'(obs_of(u)[1]), 1);
         chk("R10 read_ok timing", u, k, 32'(obs_of(u)[0]),
             32'(k >= c_dll + DLL));
         @(negedge clk);
         k++;
         n++;
      end
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      // run 1: u0, normal drive, bit 8 clear in the operating word
      drv = 1'b0;
      mw  = 13'h031;
      do_reset("R1 reset state", 3);
      walk(0);
      // run 2: u1 (final load skipped, refresh gaps outlast the DLL budget)
      drv = 1'b1;
      mw  = 13'h1FF;
      do_reset("R11 reset after ready", 2);
      walk(1);
      // run 3: reset in the middle of the sequence, then u0 again
      do_reset("R11 reset after ready", 1);
      repeat (30) @(negedge clk);
      mw = 13'h1A5;
      do_reset("R11 reset mid-sequence", 1);
      walk(0);
      summary();
      $finish;
   end

endmodule